// File: doc/BRIEF.md
# Byte Lane Steering for Load and Store Transfers

This block sits between a processor core and a 32-bit data bus. It handles whole-word and single-byte transfers. On a load it takes the word read from the bus, the two low address bits and a byte/word select. It returns the value that goes into the destination register. A byte load picks one lane by address and zero-fills everything above it. On a store it takes the source register value and produces the bus write word together with one write strobe per byte lane.

A byte store does not shift the source byte into place. It copies the low byte into every lane and leaves the choice of lane to the strobes, so the memory side updates only the addressed byte. Lanes are numbered little-endian: lane n holds bits 8n+7 down to 8n.

All three results are registered once, so each appears one clock after its inputs.

Top module: `lane_steer`

## Requirements
- R1: With byte_i low, ld_data_o equals rd_bus_i exactly.
- R2: With byte_i high, ld_data_o bits 7:0 are bus lane addr_lo_i. Address value 0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24.
- R3: With byte_i high, ld_data_o bits 31:8 are zero.
- R4: With byte_i high, wr_data_o holds st_src_i bits 7:0 in each of its four byte lanes.
- R5: With byte_i low, wr_data_o equals st_src_i exactly.
- R6: For a byte store (st_req_i high, byte_i high), wr_strb_o has exactly one bit set, at position addr_lo_i.
- R7: For word transfers addr_lo_i is ignored. A word store (st_req_i high, byte_i low) sets wr_strb_o to 4'b1111.
- R8: With st_req_i low, wr_strb_o is 4'b0000.
- R9: Every output is registered and appears one clock edge after its inputs are sampled. While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 1 | 1 = byte transfer, 0 = word transfer |
| addr_lo_i | input | 2 | Low address bits that select the byte lane |
| st_req_i | input | 1 | Store in progress; enables the write strobes |
| rd_bus_i | input | 32 | Word read from the bus |
| st_src_i | input | 32 | Source register value for a store |
| ld_data_o | output | 32 | Value for the destination register |
| wr_data_o | output | 32 | Word driven onto the bus for a store |
| wr_strb_o | output | 4 | Per-lane write strobes, bit n for lane n |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. The bench drives new inputs on a falling edge and compares the outputs on the next falling edge, when the single register stage has taken them. The checker relates each output to the inputs of the previous cycle. It starts comparing only after one full cycle out of reset, so no comparison uses inputs sampled while the registers were held in reset.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    XFER_WORD = 1'b0,
    XFER_BYTE = 1'b1
  } xfer_size_e;
endpackage

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  xfer_size_e        size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] res_o
);
  logic [LANE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (ofs_i == OFS_W'(i)) pick = bus_i[LANE_W*i +: LANE_W];
    end
  end

  // byte result is zero-extended
  assign res_o = (size_i == XFER_BYTE) ? {{(DATA_W-LANE_W){1'b0}}, pick} : bus_i;
endmodule

// File: rtl/lane_store_replicate.sv
module lane_store_replicate
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  xfer_size_e        size_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] bus_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_o[LANE_W*g +: LANE_W] =
      (size_i == XFER_BYTE) ? src_i[LANE_W-1:0] : src_i[LANE_W*g +: LANE_W];
  end
endmodule

// File: rtl/lane_strobe_decode.sv
module lane_strobe_decode
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  xfer_size_e       size_i,
  input  logic             req_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [LANES-1:0] strb_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_strb
    assign strb_o[g] = req_i & ((size_i == XFER_WORD) | (ofs_i == OFS_W'(g)));
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_i,
  input  logic [OFS_W-1:0]  addr_lo_i,
  input  logic              st_req_i,
  input  logic [DATA_W-1:0] rd_bus_i,
  input  logic [DATA_W-1:0] st_src_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_strb_o
);
  xfer_size_e        size;
  logic [DATA_W-1:0] ld_d, wr_d;
  logic [LANES-1:0]  strb_d;

  assign size = byte_i ? XFER_BYTE : XFER_WORD;

  lane_load_extract #(.DATA_W(DATA_W)) u_load (
    .size_i(size), .ofs_i(addr_lo_i), .bus_i(rd_bus_i), .res_o(ld_d)
  );

  lane_store_replicate #(.DATA_W(DATA_W)) u_store (
    .size_i(size), .src_i(st_src_i), .bus_o(wr_d)
  );

  lane_strobe_decode #(.DATA_W(DATA_W)) u_strb (
    .size_i(size), .req_i(st_req_i), .ofs_i(addr_lo_i), .strb_o(strb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_data_o <= '0;
      wr_data_o <= '0;
      wr_strb_o <= '0;
    end else begin
      ld_data_o <= ld_d;
      wr_data_o <= wr_d;
      wr_strb_o <= strb_d;
    end
  end
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_i,
  input logic [OFS_W-1:0]  addr_lo_i,
  input logic              st_req_i,
  input logic [DATA_W-1:0] rd_bus_i,
  input logic [DATA_W-1:0] st_src_i,
  input logic [DATA_W-1:0] ld_data_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [LANES-1:0]  wr_strb_o
);
  logic              live_q;
  logic [DATA_W-1:0] lane_sh;
  logic [7:0]        src_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assign lane_sh = rd_bus_i >> {addr_lo_i, 3'b000};
  assign src_b   = st_src_i[7:0];

  a_r1_word_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(byte_i)) |-> ld_data_o == $past(rd_bus_i));

  a_r2_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(byte_i)) |-> ld_data_o[7:0] == $past(lane_sh[7:0]));

  a_r3_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(byte_i)) |-> ld_data_o[DATA_W-1:8] == '0);

  a_r4_replicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(byte_i)) |-> wr_data_o == {LANES{$past(src_b)}});

  a_r5_word_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(byte_i)) |-> wr_data_o == $past(st_src_i));

  a_r6_byte_strb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(byte_i) && $past(st_req_i)) |->
      ($countones(wr_strb_o) == 1 && wr_strb_o[$past(addr_lo_i)]));

  a_r7_word_strb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(byte_i) && $past(st_req_i)) |-> &wr_strb_o);

  a_r8_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(st_req_i)) |-> wr_strb_o == '0);

  a_r9_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (ld_data_o == '0 && wr_data_o == '0 && wr_strb_o == '0));
endmodule

bind lane_steer lane_steer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .addr_lo_i(addr_lo_i),
  .st_req_i(st_req_i), .rd_bus_i(rd_bus_i), .st_src_i(st_src_i),
  .ld_data_o(ld_data_o), .wr_data_o(wr_data_o), .wr_strb_o(wr_strb_o)
);

// File: tb/lane_steer_test.sv
module lane_steer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_sel = 1'b0;
  logic [1:0]  addr = '0;
  logic        st_req = 1'b0;
  logic [31:0] rd_bus = 32'h1234_5678;
  logic [31:0] st_src = 32'h9abc_def0;
  logic [31:0] ld_data, wr_data;
  logic [3:0]  wr_strb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_steer uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_sel), .addr_lo_i(addr),
    .st_req_i(st_req), .rd_bus_i(rd_bus), .st_src_i(st_src),
    .ld_data_o(ld_data), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hffff_ffff;
      2: return 32'h8143_a5c7;
      3: return 32'h0180_7f3c;
      default: return 32'hdead_beef ^ (k * 32'h0101_0907);
    endcase
  endfunction

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9 ld reset", ld_data, 32'h0);
    chk("R9 wr reset", wr_data, 32'h0);
    chk("R9 strb reset", {28'h0, wr_strb}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 2; b++) begin
        for (int a = 0; a < 4; a++) begin
          for (int s = 0; s < 2; s++) begin
            logic [31:0] e_ld, e_wr, e_st;
            rd_bus   = pat(k);
            st_src   = pat(5 - k) ^ 32'h5a00_0000;
            byte_sel = b[0];
            addr     = a[1:0];
            st_req   = s[0];
            if (b == 1) begin
              e_ld = (rd_bus >> (8 * a)) & 32'hff;
              e_wr = (st_src & 32'hff) * 32'h0101_0101;
              e_st = s ? (32'h1 << a) : 32'h0;
            end else begin
              e_ld = rd_bus;
              e_wr = st_src;
              e_st = s ? 32'hf : 32'h0;
            end
            @(negedge clk);  // one register stage
            if (b == 1) begin
              chk("R2 byte lane", {24'h0, ld_data[7:0]}, e_ld);
              chk("R3 zero ext", {8'h0, ld_data[31:8]}, 32'h0);
              chk("R4 replicate", wr_data, e_wr);
              if (s == 1) chk("R6 byte strobe", {28'h0, wr_strb}, e_st);
            end else begin
              chk("R1 word load", ld_data, e_ld);
              chk("R5 word store", wr_data, e_wr);
              if (s == 1) chk("R7 word strobe", {28'h0, wr_strb}, e_st);
            end
            if (s == 0) chk("R8 no store", {28'h0, wr_strb}, 32'h0);
          end
        end
      end
    end

    // R9: outputs follow inputs by exactly one edge
    byte_sel = 1'b0; st_req = 1'b1; rd_bus = 32'hcafe_f00d; st_src = 32'h0bad_1dea;
    @(posedge clk); #1;
    chk("R9 one edge ld", ld_data, 32'hcafe_f00d);
    rd_bus = 32'h1111_2222;
    #2;
    chk("R9 held ld", ld_data, 32'hcafe_f00d);
    rst_n = 1'b0; #1;
    chk("R9 async clear", ld_data, 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule